// File: doc/BRIEF.md
# 64-bit Register File with Zero/Stack Alias

This block is the architectural register storage of a 64-bit load/store core. It holds thirty-one general registers, numbered 0 to 30, and a separate stack pointer. Two read ports and one write port address this storage with 5-bit indices. Each access also carries a width bit that selects either the full 64-bit register or a 32-bit view of its low half.

Index 31 has no register of its own. A mode bit on each port picks what index 31 means for that access. With the mode bit low, index 31 is a zero register: it always reads as zero, and writes to it are discarded. With the mode bit high, index 31 is the stack pointer. A separate branch-and-link strobe stores a return address into register 30 during the same cycle as an ordinary port write.

Reads are combinational. Writes take effect at the rising clock edge. The stack pointer loads a value supplied on an input while reset is held. The general registers have no reset value.

Top module: `xreg_file`

## Requirements
- R1: Registers 0 to 30 are each 64 bits wide. A full-width write (wrNarrow=0) to index i at a clock edge is returned by a full-width read of i from that edge on. A read in the same cycle as the write returns the old value.
- R2: A 32-bit read (rdNarrow=1) returns bits 31:0 of the named register in bits 31:0 of the output, with bits 63:32 of the output at zero.
- R3: A read of index 31 with its mode bit at 0 (zero mode) returns 0 at either width.
- R4: A write to index 31 with wrSpMode=0 changes neither the stack pointer nor any general register.
- R5: A 32-bit write (wrNarrow=1) stores bits 31:0 of wrData and clears bits 63:32 of the destination.
- R6: Index 31 with its mode bit at 1 reads and writes the stack pointer. A 32-bit read of it returns its low half zero-extended, and a 32-bit write to it clears its upper half.
- R7: When linkEn is high at a clock edge, register 30 takes the full 64-bit linkAddr.
- R8: If linkEn is high and the port writes index 30 in the same cycle, register 30 takes linkAddr. A port write to any other index in that cycle still takes effect.
- R9: At every clock edge with rstN low, the stack pointer loads spResetVal. The general registers are left undefined.
- R10: The two read ports are independent. Each one applies its own index, mode and width in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low; loads the stack pointer |
| spResetVal | input | 64 | Value the stack pointer takes during reset |
| rdIdxA | input | 5 | Read port A register index |
| rdSpModeA | input | 1 | Read port A: index 31 means stack pointer (1) or zero (0) |
| rdNarrowA | input | 1 | Read port A: 1 selects the 32-bit view |
| rdDataA | output | 64 | Read port A data |
| rdIdxB | input | 5 | Read port B register index |
| rdSpModeB | input | 1 | Read port B: index 31 means stack pointer (1) or zero (0) |
| rdNarrowB | input | 1 | Read port B: 1 selects the 32-bit view |
| rdDataB | output | 64 | Read port B data |
| wrEn | input | 1 | Write port enable |
| wrIdx | input | 5 | Write port register index |
| wrSpMode | input | 1 | Write port: index 31 means stack pointer (1) or zero (0) |
| wrNarrow | input | 1 | Write port: 1 selects a 32-bit write |
| wrData | input | 64 | Write port data |
| linkEn | input | 1 | Branch-and-link strobe, writes register 30 |
| linkAddr | input | 64 | Return address stored by the strobe |

## Verification
Internal state is visible on the read ports in the cycle after it changes, because reads are combinational.

A stray write caused by a wrongly decoded alias index shows up as a wrong value at the next read of the stack pointer or of the corrupted register. Losing the link priority, or leaving stale upper bits after a 32-bit write, shows up the same way: the next full-width read of register 30, of the destination register or of the stack pointer returns the wrong value.

The bench compares both read ports with a behavioural model in every cycle. A corrupted register is therefore reported as soon as either port names it.

// File: rtl/xreg_pkg.sv
package xreg_pkg;
  localparam int XR_DATA_W   = 64;
  localparam int XR_NUM_GPR  = 31;
  localparam int XR_IDX_W    = $clog2(XR_NUM_GPR + 1);
  localparam int XR_LINK_IDX = 30;

  // per read port: what the index resolves to
  typedef struct packed {
    logic                isZero;
    logic                isSp;
    logic [XR_IDX_W-1:0] idx;
    logic                narrow;
  } rdSel_t;

  // write strobes from control to datapath
  typedef struct packed {
    logic                gprWe;
    logic [XR_IDX_W-1:0] gprSel;
    logic                spWe;
    logic                narrow;
    logic                linkWe;
  } wrStrobe_t;
endpackage

// File: rtl/xreg_ctrl.sv
module xreg_ctrl
  import xreg_pkg::*;
#(
  parameter int NUM_RD   = 2,
  parameter int LINK_IDX = XR_LINK_IDX
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [NUM_RD-1:0][XR_IDX_W-1:0]  rdIdx,
  input  logic [NUM_RD-1:0]                rdSpMode,
  input  logic [NUM_RD-1:0]                rdNarrow,
  output rdSel_t [NUM_RD-1:0]              rdSel,
  input  logic                             wrEn,
  input  logic [XR_IDX_W-1:0]              wrIdx,
  input  logic                             wrSpMode,
  input  logic                             wrNarrow,
  input  logic                             linkEn,
  output wrStrobe_t                        wrStb
);
  localparam logic [XR_IDX_W-1:0] ALIAS_IDX = XR_IDX_W'((1 << XR_IDX_W) - 1);
  localparam logic [XR_IDX_W-1:0] LINK_SEL  = XR_IDX_W'(LINK_IDX);

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    logic aliasHit;
    assign aliasHit = (rdIdx[p] == ALIAS_IDX);
    assign rdSel[p] = '{isZero: aliasHit && !rdSpMode[p],
                        isSp:   aliasHit &&  rdSpMode[p],
                        idx:    rdIdx[p],
                        narrow: rdNarrow[p]};
  end

  logic wrAliasHit;
  logic linkClash;

  always_comb begin
    wrAliasHit   = (wrIdx == ALIAS_IDX);
    linkClash    = linkEn && (wrIdx == LINK_SEL);
    wrStb.gprWe  = wrEn && !wrAliasHit && !linkClash;
    wrStb.gprSel = wrIdx;
    wrStb.spWe   = wrEn && wrAliasHit && wrSpMode;
    wrStb.narrow = wrNarrow;
    wrStb.linkWe = linkEn;
  end

  // R4: a zero-mode write of the alias index raises no strobe
  p_zero_sink_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrIdx == ALIAS_IDX && !wrSpMode) |-> !(wrStb.gprWe || wrStb.spWe));

  // R8: the strobe beats the port on register 30
  p_link_priority_r8: assert property (@(posedge clk) disable iff (!rstN)
    (linkEn && wrIdx == LINK_SEL) |-> !wrStb.gprWe);
endmodule

// File: rtl/xreg_datapath.sv
module xreg_datapath
  import xreg_pkg::*;
#(
  parameter int DATA_W   = XR_DATA_W,
  parameter int NUM_GPR  = XR_NUM_GPR,
  parameter int LINK_IDX = XR_LINK_IDX,
  parameter int NUM_RD   = 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [DATA_W-1:0]              spResetVal,
  input  wrStrobe_t                      wrStb,
  input  logic [DATA_W-1:0]              wrData,
  input  logic [DATA_W-1:0]              linkAddr,
  input  rdSel_t [NUM_RD-1:0]            rdSel,
  output logic [NUM_RD-1:0][DATA_W-1:0]  rdData
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] gpr [NUM_GPR];
  logic [DATA_W-1:0] sp;
  logic [DATA_W-1:0] wrVal;

  assign wrVal = wrStb.narrow ? {{(DATA_W-HALF_W){1'b0}}, wrData[HALF_W-1:0]} : wrData;

  always_ff @(posedge clk) begin
    if (wrStb.gprWe)  gpr[wrStb.gprSel] <= wrVal;
    if (wrStb.linkWe) gpr[LINK_IDX]     <= linkAddr;
  end

  always_ff @(posedge clk) begin
    if (!rstN)           sp <= spResetVal;
    else if (wrStb.spWe) sp <= wrVal;
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rdPort
    logic [DATA_W-1:0] raw;
    always_comb begin
      if (rdSel[p].isZero)    raw = '0;
      else if (rdSel[p].isSp) raw = sp;
      else                    raw = gpr[rdSel[p].idx];
    end
    assign rdData[p] = rdSel[p].narrow ? {{(DATA_W-HALF_W){1'b0}}, raw[HALF_W-1:0]} : raw;
  end

  // R7: the strobe lands its address in register 30
  p_link_store_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(wrStb.linkWe)) |-> (gpr[LINK_IDX] == $past(linkAddr)));

  // R4: the stack pointer moves only on its own strobe
  p_sp_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(wrStb.spWe)) |-> $stable(sp));

  // R6: a 32-bit stack pointer write leaves the upper half clear
  p_sp_narrow_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(wrStb.spWe && wrStb.narrow)) |-> (sp[DATA_W-1:HALF_W] == '0));
endmodule

// File: rtl/xreg_file.sv
module xreg_file
  import xreg_pkg::*;
#(
  parameter int DATA_W   = XR_DATA_W,
  parameter int NUM_GPR  = XR_NUM_GPR,
  parameter int LINK_IDX = XR_LINK_IDX
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [DATA_W-1:0]   spResetVal,
  input  logic [XR_IDX_W-1:0] rdIdxA,
  input  logic                rdSpModeA,
  input  logic                rdNarrowA,
  output logic [DATA_W-1:0]   rdDataA,
  input  logic [XR_IDX_W-1:0] rdIdxB,
  input  logic                rdSpModeB,
  input  logic                rdNarrowB,
  output logic [DATA_W-1:0]   rdDataB,
  input  logic                wrEn,
  input  logic [XR_IDX_W-1:0] wrIdx,
  input  logic                wrSpMode,
  input  logic                wrNarrow,
  input  logic [DATA_W-1:0]   wrData,
  input  logic                linkEn,
  input  logic [DATA_W-1:0]   linkAddr
);
  localparam int NUM_RD = 2;
  localparam int HALF_W = DATA_W / 2;
  localparam logic [XR_IDX_W-1:0] ALIAS_IDX = XR_IDX_W'((1 << XR_IDX_W) - 1);

  logic [NUM_RD-1:0][XR_IDX_W-1:0] rdIdxV;
  logic [NUM_RD-1:0]               rdSpModeV;
  logic [NUM_RD-1:0]               rdNarrowV;
  logic [NUM_RD-1:0][DATA_W-1:0]   rdDataV;
  rdSel_t [NUM_RD-1:0]             rdSel;
  wrStrobe_t                       wrStb;

  assign rdIdxV    = {rdIdxB, rdIdxA};
  assign rdSpModeV = {rdSpModeB, rdSpModeA};
  assign rdNarrowV = {rdNarrowB, rdNarrowA};
  assign rdDataA   = rdDataV[0];
  assign rdDataB   = rdDataV[1];

  xreg_ctrl #(.NUM_RD(NUM_RD), .LINK_IDX(LINK_IDX)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .rdIdx(rdIdxV), .rdSpMode(rdSpModeV), .rdNarrow(rdNarrowV), .rdSel(rdSel),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrSpMode(wrSpMode), .wrNarrow(wrNarrow),
    .linkEn(linkEn), .wrStb(wrStb)
  );

  xreg_datapath #(.DATA_W(DATA_W), .NUM_GPR(NUM_GPR), .LINK_IDX(LINK_IDX), .NUM_RD(NUM_RD)) i_dp (
    .clk(clk), .rstN(rstN), .spResetVal(spResetVal),
    .wrStb(wrStb), .wrData(wrData), .linkAddr(linkAddr),
    .rdSel(rdSel), .rdData(rdDataV)
  );

  // R3: zero-mode alias reads are zero on both ports
  p_zero_read_a_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rdIdxA == ALIAS_IDX && !rdSpModeA) |-> (rdDataA == '0));
  p_zero_read_b_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rdIdxB == ALIAS_IDX && !rdSpModeB) |-> (rdDataB == '0));

  // R2: 32-bit reads never drive the upper half
  p_narrow_read_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rdNarrowA |-> rdDataA[DATA_W-1:HALF_W] == '0) and (rdNarrowB |-> rdDataB[DATA_W-1:HALF_W] == '0));
endmodule

// File: tb/test_xreg_file.sv
`timescale 1ns/1ps
module test_xreg_file;
  logic        clk = 1'b0;
  logic        rstN;
  logic [63:0] spResetVal;
  logic [4:0]  rdIdxA, rdIdxB, wrIdx;
  logic        rdSpModeA, rdNarrowA, rdSpModeB, rdNarrowB;
  logic [63:0] rdDataA, rdDataB, wrData, linkAddr;
  logic        wrEn, wrSpMode, wrNarrow, linkEn;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [63:0] mGpr [31];
  bit          mVal [31];
  logic [63:0] mSp;

  always #10 clk = ~clk;

  xreg_file i_xreg_file (
    .clk(clk), .rstN(rstN), .spResetVal(spResetVal),
    .rdIdxA(rdIdxA), .rdSpModeA(rdSpModeA), .rdNarrowA(rdNarrowA), .rdDataA(rdDataA),
    .rdIdxB(rdIdxB), .rdSpModeB(rdSpModeB), .rdNarrowB(rdNarrowB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrSpMode(wrSpMode), .wrNarrow(wrNarrow), .wrData(wrData),
    .linkEn(linkEn), .linkAddr(linkAddr)
  );

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  function automatic string autoTag(logic [4:0] idx, logic mode, logic narrow);
    if (idx == 5'd31 && !mode) return "R3";
    if (idx == 5'd31) return "R6";
    if (narrow) return "R2";
    return "R1";
  endfunction

  task automatic cmpPort(string tag, string port, logic [4:0] idx, logic mode, logic narrow, logic [63:0] act);
    logic [63:0] exp;
    bit known;
    if (idx == 5'd31) begin
      known = 1;
      exp = mode ? mSp : 64'd0;
    end else begin
      known = mVal[idx];
      exp = mGpr[idx];
    end
    if (narrow) exp = {32'd0, exp[31:0]};
    if (known) begin
      checks++;
      if (act !== exp) begin
        failures++;
        $display("FAIL %s port %s idx=%0d mode=%0b narrow=%0b actual=%h expected=%h",
                 (tag == "") ? autoTag(idx, mode, narrow) : tag, port, idx, mode, narrow, act, exp);
      end
    end
  endtask

  task automatic modelUpdate();
    logic [63:0] v;
    v = wrNarrow ? {32'd0, wrData[31:0]} : wrData;
    if (wrEn) begin
      if (wrIdx == 5'd31) begin
        if (wrSpMode) mSp = v;
      end else if (!(wrIdx == 5'd30 && linkEn)) begin
        mGpr[wrIdx] = v;
        mVal[wrIdx] = 1;
      end
    end
    if (linkEn) begin
      mGpr[30] = linkAddr;
      mVal[30] = 1;
    end
  endtask

  // called just after a falling edge with inputs already set
  task automatic step(string tag);
    #1;
    cmpPort(tag, "A", rdIdxA, rdSpModeA, rdNarrowA, rdDataA);
    cmpPort(tag, "B", rdIdxB, rdSpModeB, rdNarrowB, rdDataB);
    @(posedge clk);
    #1;
    modelUpdate();
    @(negedge clk);
    wrEn = 0;
    linkEn = 0;
  endtask

  task automatic setRd(logic [4:0] ia, logic ma, logic na, logic [4:0] ib, logic mb, logic nb);
    rdIdxA = ia; rdSpModeA = ma; rdNarrowA = na;
    rdIdxB = ib; rdSpModeB = mb; rdNarrowB = nb;
  endtask

  task automatic setWr(logic [4:0] idx, logic mode, logic narrow, logic [63:0] d);
    wrEn = 1; wrIdx = idx; wrSpMode = mode; wrNarrow = narrow; wrData = d;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
    end
  end

  initial begin
    rstN = 0;
    spResetVal = 64'hFFFF_0000_1234_5670;
    wrEn = 0; wrIdx = 0; wrSpMode = 0; wrNarrow = 0; wrData = 0;
    linkEn = 0; linkAddr = 0;
    setRd(5'd31, 1'b1, 1'b0, 5'd31, 1'b1, 1'b1);
    for (int i = 0; i < 31; i++) begin mVal[i] = 0; mGpr[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    mSp = spResetVal;

    // R9: stack pointer reset value, full and narrow
    step("R9");

    // R1: fill every register, reading back the previous one; port B reads the one being written
    for (int i = 0; i < 31; i++) begin
      setWr(5'(i), 1'b0, 1'b0, {32'hA5A5_0000 | 32'(i), ~32'(i * 7)});
      setRd(5'((i + 30) % 31), 1'b0, 1'b0, 5'(i), 1'b0, 1'b0);
      step("R1");
    end
    setRd(5'd30, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0);
    step("R1");

    // R2: narrow reads of registers with upper bits set
    setRd(5'd4, 1'b0, 1'b1, 5'd17, 1'b1, 1'b1);
    step("R2");

    // R5: narrow write clears the upper half
    setWr(5'd5, 1'b0, 1'b1, 64'hDEAD_BEEF_CAFE_F00D);
    step("R5");
    setRd(5'd5, 1'b0, 1'b0, 5'd5, 1'b0, 1'b1);
    step("R5");

    // R4: zero-mode write of index 31 touches nothing
    setWr(5'd31, 1'b0, 1'b0, 64'h1111_2222_3333_4444);
    setRd(5'd31, 1'b0, 1'b0, 5'd31, 1'b1, 1'b0);
    step("R4");
    setRd(5'd31, 1'b1, 1'b0, 5'd31, 1'b0, 1'b1);
    step("R4");
    for (int i = 0; i < 31; i += 2) begin
      setRd(5'(i), 1'b0, 1'b0, 5'(i + 1 < 31 ? i + 1 : 0), 1'b0, 1'b0);
      step("R4");
    end

    // R3: zero register reads at both widths
    setRd(5'd31, 1'b0, 1'b0, 5'd31, 1'b0, 1'b1);
    step("R3");

    // R6: stack pointer full and narrow writes and reads
    setWr(5'd31, 1'b1, 1'b0, 64'h0123_4567_89AB_CDE0);
    step("R6");
    setRd(5'd31, 1'b1, 1'b0, 5'd31, 1'b1, 1'b1);
    step("R6");
    setWr(5'd31, 1'b1, 1'b1, 64'hFFFF_FFFF_0000_1000);
    step("R6");
    setRd(5'd31, 1'b1, 1'b0, 5'd31, 1'b0, 1'b0);
    step("R6");

    // R7: link strobe alone
    linkEn = 1; linkAddr = 64'h0000_0040_0000_1234;
    step("R7");
    setRd(5'd30, 1'b0, 1'b0, 5'd30, 1'b0, 1'b1);
    step("R7");

    // R8: link and port both on register 30, then on different registers
    linkEn = 1; linkAddr = 64'h0000_0040_0000_5678;
    setWr(5'd30, 1'b0, 1'b0, 64'hBAD0_BAD0_BAD0_BAD0);
    step("R8");
    setRd(5'd30, 1'b0, 1'b0, 5'd7, 1'b0, 1'b0);
    step("R8");
    linkEn = 1; linkAddr = 64'h0000_0040_0000_9ABC;
    setWr(5'd7, 1'b0, 1'b0, 64'h7777_0000_7777_0000);
    step("R8");
    setRd(5'd30, 1'b0, 1'b0, 5'd7, 1'b0, 1'b0);
    step("R8");

    // R10: ports with different index, mode and width in one cycle
    setRd(5'd31, 1'b1, 1'b1, 5'd12, 1'b0, 1'b0);
    step("R10");
    setRd(5'd9, 1'b0, 1'b1, 5'd31, 1'b0, 1'b0);
    step("R10");

    // mixed traffic, tags chosen by access kind
    for (int n = 0; n < 400; n++) begin
      setRd(5'($urandom_range(31, 0)), 1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)),
            5'($urandom_range(31, 0)), 1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)));
      if ($urandom_range(3, 0) != 0) begin
        setWr(($urandom_range(3, 0) == 0) ? 5'(30 + $urandom_range(1, 0)) : 5'($urandom_range(31, 0)),
              1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)), {$urandom, $urandom});
      end
      if ($urandom_range(7, 0) == 0) begin
        linkEn = 1;
        linkAddr = {$urandom, $urandom};
      end
      step("");
    end

    summary();
  end
endmodule